// File: doc/BRIEF.md
# Quad-Channel Serial ADC Sample Reader

This block fetches one 12-bit conversion from an external four-input serial ADC. A request gives the SPI port the converter sits on and the input channel to convert. The block then runs a fixed bus exchange of three bytes on that port. It selects the converter and sends a command byte that names the channel. It clocks in two reply bytes and releases the select. Finally it splices the 12-bit sample out of the two reply bytes and presents it for one cycle, tagged with the port and channel it came from.

The bit-level SPI shifter is part of the block and runs in mode 0: the clock idles low, MOSI is set up before each rising edge, and MISO is sampled on each rising edge. One shifter is shared by all ports. Only the selected port's chip select, clock and data-out ever move. A divisor input sets the bit rate. For example, a 250 kHz bit clock from a 250 MHz system clock needs a divisor of 499.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, so an upstream source must hold its request until it sees ready. The result side has no back-pressure. The consumer must take `res_data` in the single cycle that `res_valid` is high.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset, every `spi_cs_n` bit is 1 and every `spi_sclk` bit is 0. `busy` and `res_valid` are 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` equals the inverse of `busy`.
- R3: A taken request for port p pulls `spi_cs_n[p]` low before the first clock pulse. It then gives exactly 24 rising `spi_sclk[p]` edges and raises `spi_cs_n[p]` again before the result appears. Other ports' select, clock and data-out stay at 1, 0 and 0.
- R4: The first byte shifted out on MOSI, MSB first, is the channel number c (0..3) shifted left by one, OR-ed with 0x30, and that value shifted left by one more. This gives 0x60, 0x64, 0x68 and 0x6C.
- R5: With reply bytes B1 (second byte on MISO) and B2 (third byte), `res_data` is ((B1 << 4) & 0xFF0) | ((B2 >> 4) & 0xF). The MISO byte received while the command goes out is discarded.
- R6: The low four bits of B2 have no effect on `res_data`.
- R7: `res_valid` is high for exactly one cycle per taken request. In that cycle `res_port` and `res_chan` equal the request's port and channel.
- R8: `busy` rises the cycle after a request is taken and stays high through the `res_valid` cycle. It falls in the cycle after that. A request offered while busy is not taken and leaves no trace.
- R9: Each high and each low half of `spi_sclk` lasts `clk_div`+1 system cycles. `clk_div` is captured at the start of each byte.
- R10: MOSI holds steady while `spi_sclk` is high. MISO is sampled at the rising edge of `spi_sclk`.
- R11: A request whose port is NUM_PORTS or above is taken and dropped. No chip select moves, no result appears, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period of the SPI clock, in system cycles, minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_port | input | PORT_W | SPI port of the converter |
| req_chan | input | 2 | Converter input channel |
| busy | output | 1 | A read is in progress |
| res_valid | output | 1 | One-cycle pulse: result present |
| res_port | output | PORT_W | Port the result belongs to |
| res_chan | output | 2 | Channel the result belongs to |
| res_data | output | 12 | Assembled sample |
| spi_sclk | output | NUM_PORTS | Per-port SPI clock |
| spi_mosi | output | NUM_PORTS | Per-port data to converter |
| spi_miso | input | NUM_PORTS | Per-port data from converter |
| spi_cs_n | output | NUM_PORTS | Per-port active-low select |

## Verification
Reads are run on every port and several channels. Each read uses reply bytes chosen to separate the splice from look-alikes. Alternating bit patterns expose a wrong shift amount. All-ones in the kept bits with zeros below shows masking of the discarded nibble. Zeros in the kept bits with ones in the discarded nibble shows whether those low bits leak in. Divisors of 0, 1, 3 and 499 separate a correct half-period count from an off-by-one. A converter model on each port captures the command byte and counts clock edges, so a mis-routed port or a wrong channel field shows up directly. Requests offered while busy, and a request for a port that does not exist, confirm that stray handshakes leave no mark on any port or result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int BYTE_W   = 8;
  localparam int CHAN_W   = 2;
  localparam int SAMPLE_W = 12;
  localparam int NIB_W    = SAMPLE_W - BYTE_W;
  localparam int XFER_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_FINISH
  } seq_state_e;

  // Command: base pattern with channel field, shifted up by one.
  function automatic logic [BYTE_W-1:0] make_cmd(input logic [CHAN_W-1:0] ch);
    logic [BYTE_W-1:0] t;
    t = 8'h30 | (BYTE_W'(ch) << 1);
    return t << 1;
  endfunction

  // Sample: whole first reply byte on top, upper nibble of the second below.
  function automatic logic [SAMPLE_W-1:0] splice(input logic [BYTE_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return {hi, lo[BYTE_W-1 -: NIB_W]};
  endfunction

endpackage

// File: rtl/adc_spi_byte.sv
module adc_spi_byte
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic              active;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] sh_tx;
  logic [BYTE_W-1:0] sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      div_q  <= '0;
      cnt    <= '0;
      bitn   <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      sclk   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          div_q  <= clk_div;
          cnt    <= '0;
          bitn   <= '0;
          sh_tx  <= tx_byte;
          sclk   <= 1'b0;
        end
      end else if (cnt == div_q) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[BYTE_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == BIT_W'(BYTE_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            sh_tx <= {sh_tx[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mosi    = active & sh_tx[BYTE_W-1];
  assign rx_byte = sh_rx;

  // R10: data out is frozen across every high half of the clock
  a_r10_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9: the clock only runs inside a byte
  a_r9_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> !sclk);

endmodule

// File: rtl/adc_rd_ctl.sv
module adc_rd_ctl
  import adc_seq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PORT_W-1:0]   req_port,
  input  logic [CHAN_W-1:0]   req_chan,
  output logic                busy,
  output logic                eng_start,
  output logic [BYTE_W-1:0]   eng_tx,
  input  logic                eng_done,
  input  logic [BYTE_W-1:0]   eng_rx,
  output logic                cs_en,
  output logic [PORT_W-1:0]   port_q,
  output logic                res_valid,
  output logic [PORT_W-1:0]   res_port,
  output logic [CHAN_W-1:0]   res_chan,
  output logic [SAMPLE_W-1:0] res_data
);

  localparam int IDX_W = $clog2(XFER_BYTES);

  seq_state_e        state;
  logic [CHAN_W-1:0] chan_q;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic              take;
  logic              port_ok;
  logic              last_byte;

  assign port_ok   = int'(req_port) < NUM_PORTS;
  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign last_byte = (idx == IDX_W'(XFER_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      port_q <= '0;
      chan_q <= '0;
      idx    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take && port_ok) begin
            port_q <= req_port;
            chan_q <= req_chan;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          idx   <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (eng_done) begin
            if (idx == IDX_W'(1)) hi_q <= eng_rx;
            if (last_byte) begin
              lo_q  <= eng_rx;
              state <= ST_TRAIL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_TRAIL:  state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cs_en     = (state == ST_LEAD) || (state == ST_SHIFT);
  assign eng_start = (state == ST_LEAD) ||
                     ((state == ST_SHIFT) && eng_done && !last_byte);
  assign eng_tx    = (state == ST_LEAD) ? make_cmd(chan_q) : '0;

  assign res_valid = (state == ST_FINISH);
  assign res_port  = port_q;
  assign res_chan  = chan_q;
  assign res_data  = splice(hi_q, lo_q);

  // R7: result strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8: busy still high while the result is shown
  a_r8_busy_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  // R8: target held for the whole read
  a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(port_q) && $stable(chan_q)));

  // R3: select released before the result is shown
  a_r3_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cs_en);

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DIV_W     = 16,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PORT_W-1:0]    req_port,
  input  logic [1:0]           req_chan,
  output logic                 busy,
  output logic                 res_valid,
  output logic [PORT_W-1:0]    res_port,
  output logic [1:0]           res_chan,
  output logic [11:0]          res_data,
  output logic [NUM_PORTS-1:0] spi_sclk,
  output logic [NUM_PORTS-1:0] spi_mosi,
  input  logic [NUM_PORTS-1:0] spi_miso,
  output logic [NUM_PORTS-1:0] spi_cs_n
);

  logic              eng_start;
  logic [BYTE_W-1:0] eng_tx;
  logic [BYTE_W-1:0] eng_rx;
  logic              eng_done;
  logic              eng_sclk;
  logic              eng_mosi;
  logic              miso_sel;
  logic              cs_en;
  logic [PORT_W-1:0] port_q;

  adc_rd_ctl #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_port  (req_port),
    .req_chan  (req_chan),
    .busy      (busy),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .cs_en     (cs_en),
    .port_q    (port_q),
    .res_valid (res_valid),
    .res_port  (res_port),
    .res_chan  (res_chan),
    .res_data  (res_data)
  );

  adc_spi_byte #(
    .DIV_W (DIV_W)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_div (clk_div),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .rx_byte (eng_rx),
    .done    (eng_done),
    .sclk    (eng_sclk),
    .mosi    (eng_mosi),
    .miso    (miso_sel)
  );

  always_comb begin
    miso_sel = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_q == PORT_W'(p)) miso_sel = spi_miso[p];
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    logic sel;
    assign sel          = (port_q == PORT_W'(gp));
    assign spi_cs_n[gp] = !(cs_en && sel);
    assign spi_sclk[gp] = eng_sclk && sel;
    assign spi_mosi[gp] = eng_mosi && sel;
  end

  // R3: never more than one converter selected
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R3: clock edges only reach a selected converter
  a_r3_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (|spi_sclk) |-> !(&spi_cs_n));

  // R11: idle with no accepted target keeps every select high
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&spi_cs_n));

endmodule

// File: tb/adc_rd_seq_bench.sv
module adc_rd_seq_bench;

  localparam int NP    = 3;
  localparam int DW    = 16;
  localparam int PW    = 2;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] clk_div = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_port = '0;
  logic [1:0]    req_chan = '0;
  logic          busy;
  logic          res_valid;
  logic [PW-1:0] res_port;
  logic [1:0]    res_chan;
  logic [11:0]   res_data;
  logic [NP-1:0] spi_sclk;
  logic [NP-1:0] spi_mosi;
  logic [NP-1:0] spi_miso;
  logic [NP-1:0] spi_cs_n;

  int checks = 0;
  int fails  = 0;
  int stray  = 0;
  int pulses = 0;
  int exp_port = -1;
  logic [23:0] resp_word = '0;

  always #2 clk = ~clk;

  adc_rd_seq #(.NUM_PORTS(NP), .DIV_W(DW)) u_adc_rd_seq (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_chan(req_chan), .busy(busy),
    .res_valid(res_valid), .res_port(res_port), .res_chan(res_chan),
    .res_data(res_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // Converter models, one per port, sampled on the falling system edge
  logic [23:0] cap    [NP];
  int          rises  [NP];
  int          idx    [NP];
  int          hi_run [NP];
  int          hi_min [NP];
  int          hi_max [NP];

  for (genvar gp = 0; gp < NP; gp++) begin : g_model
    logic prev_sclk = 1'b0;
    logic prev_cs   = 1'b1;
    assign spi_miso[gp] = resp_word[5'(23 - idx[gp])];
    always @(negedge clk) begin
      if (prev_cs && !spi_cs_n[gp]) begin
        cap[gp] <= '0; rises[gp] <= 0; idx[gp] <= 0;
        hi_run[gp] <= 0; hi_min[gp] <= 1 << 30; hi_max[gp] <= 0;
      end else begin
        if (spi_sclk[gp] && !prev_sclk) begin
          cap[gp]    <= {cap[gp][22:0], spi_mosi[gp]};
          rises[gp]  <= rises[gp] + 1;
          hi_run[gp] <= 1;
        end else if (spi_sclk[gp]) begin
          hi_run[gp] <= hi_run[gp] + 1;
        end
        if (!spi_sclk[gp] && prev_sclk) begin
          if (idx[gp] < 23) idx[gp] <= idx[gp] + 1;
          if (hi_run[gp] < hi_min[gp]) hi_min[gp] <= hi_run[gp];
          if (hi_run[gp] > hi_max[gp]) hi_max[gp] <= hi_run[gp];
        end
      end
      prev_sclk <= spi_sclk[gp];
      prev_cs   <= spi_cs_n[gp];
    end
  end

  // Ports other than the expected one must stay silent (R3, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++)
        if (p != exp_port && (!spi_cs_n[p] || spi_sclk[p] || spi_mosi[p]))
          stray <= stray + 1;
      if (res_valid) pulses <= pulses + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic t_reset();
    chk(spi_cs_n == '1, "R1 cs_n", int'(spi_cs_n), 7);
    chk(spi_sclk == '0, "R1 sclk", int'(spi_sclk), 0);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!res_valid, "R1 res_valid", int'(res_valid), 0);
    chk(req_ready, "R1 req_ready", int'(req_ready), 1);
  endtask

  // One complete read with its own checks (R2..R10)
  task automatic t_read(input int port, input int chan, input int div,
                        input logic [7:0] b1, input logic [7:0] b2);
    int cyc = 0;
    int busy_bad = 0;
    logic [7:0] cmd_exp;
    logic [11:0] data_exp;
    cmd_exp  = 8'((8'h30 | (chan << 1)) << 1);
    data_exp = 12'(((b1 << 4) & 12'hFF0) | ((b2 >> 4) & 12'h00F));
    exp_port = port;
    @(negedge clk);
    clk_div   = DW'(div);
    resp_word = {8'hC3, b1, b2};
    chk(req_ready, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_port = PW'(port); req_chan = 2'(chan);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid && cyc < 60000) begin
      if (!busy || req_ready) busy_bad++;
      @(negedge clk);
      cyc++;
    end
    chk(res_valid, "R7 result arrives", int'(res_valid), 1);
    chk(busy_bad == 0, "R8 busy held, ready low", busy_bad, 0);
    chk(busy && !req_ready, "R8 busy at result", int'(busy), 1);
    chk(res_data == data_exp, "R5 sample", int'(res_data), int'(data_exp));
    chk(int'(res_port) == port, "R7 port tag", int'(res_port), port);
    chk(int'(res_chan) == chan, "R7 chan tag", int'(res_chan), chan);
    chk(cap[port][23:16] == cmd_exp, "R4 command byte", int'(cap[port][23:16]), int'(cmd_exp));
    chk(rises[port] == 24, "R3 clock edges", rises[port], 24);
    chk(spi_cs_n[port], "R3 select released", int'(spi_cs_n[port]), 1);
    chk(hi_min[port] == div + 1 && hi_max[port] == div + 1, "R9 high half length",
        hi_max[port], div + 1);
    @(negedge clk);
    chk(!res_valid, "R7 pulse one cycle", int'(res_valid), 0);
    chk(!busy && req_ready, "R8 busy falls after result", int'(busy), 0);
    chk(stray == 0, "R3 other ports quiet", stray, 0);
    exp_port = -1;
  endtask

  // Requests offered while busy are not taken (R8)
  task automatic t_busy_ignore();
    int p0;
    int cyc = 0;
    p0 = pulses;
    exp_port = 1;
    @(negedge clk);
    clk_div = DW'(1); resp_word = {8'h00, 8'h12, 8'h30};
    req_valid = 1'b1; req_port = 2'd1; req_chan = 2'd2;
    @(negedge clk);
    req_port = 2'd2; req_chan = 2'd1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(int'(res_port) == 1 && int'(res_chan) == 2, "R8 ignored request tag",
        int'(res_port), 1);
    chk(res_data == 12'h123, "R8 ignored request data", int'(res_data), 'h123);
    repeat (200) @(negedge clk);
    chk(pulses - p0 == 1, "R8 single result", pulses - p0, 1);
    chk(stray == 0, "R8 no activity on offered port", stray, 0);
    exp_port = -1;
  endtask

  // Port outside the range is consumed and dropped (R11)
  task automatic t_bad_port();
    int p0;
    int bz = 0;
    p0 = pulses;
    @(negedge clk);
    req_valid = 1'b1; req_port = 2'd3; req_chan = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (300) begin @(negedge clk); if (busy) bz++; end
    chk(bz == 0, "R11 busy stays low", bz, 0);
    chk(pulses == p0, "R11 no result", pulses - p0, 0);
    chk(stray == 0 && spi_cs_n == '1, "R11 no select", int'(spi_cs_n), 7);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      cap[p] = '0; rises[p] = 0; idx[p] = 0;
      hi_run[p] = 0; hi_min[p] = 0; hi_max[p] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(0, 0, 0, 8'hA5, 8'h3C);
    t_read(1, 3, 1, 8'hFF, 8'hF0);
    t_read(2, 2, 3, 8'h00, 8'h0F);    // R6: low nibble of second byte dropped
    t_read(0, 1, 2, 8'h81, 8'h7E);
    t_read(2, 0, 0, 8'h5A, 8'hA5);
    t_read(1, 1, 499, 8'h3C, 8'hC3);  // 250 kHz bit clock from 250 MHz
    t_busy_ignore();
    t_bad_port();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule